// File: doc/BRIEF.md
# Clock Run Request Controller

This block sits beside a serial interrupt encoder. It makes sure the shared bus clock is running whenever an interrupt line has changed and that change has not yet gone out to the host. The clock-run line is active low and open drain. The host pulls it high to announce that the clock is about to stop, or has stopped. Any agent may pull it low to ask for the clock.

The block synchronizes the interrupt request lines and compares each new sample with the previous one. Any difference raises a pending-change flag. While that flag is set and serial interrupts are enabled, the block watches the line. Each time it samples the line high, it pulls the line low for a fixed minimum number of clocks and then lets go. It repeats this for as long as the change is still waiting. A single-cycle completion pulse from the encoder clears the flag. If a new change is detected in that same cycle, the flag stays set.

Top module: `clkRunReq`

## Requirements
- R1: A change in either direction on any bit of `irqLines` sets `changePending` at the third rising clock edge after the input changes. Two of those edges are synchronizer stages and one is the compare register.
- R2: `clkRunOe` (1 = pull the line low) rises only at an edge where `changePending` was 1, `serIrqEn` was 1 and `clkRunIn` was sampled high.
- R3: Once raised, `clkRunOe` stays 1 for exactly MIN_DRIVE clock cycles (default 2) and then returns to 0, whatever the other inputs do.
- R4: If the change is still pending and the line is sampled high again after a release, `clkRunOe` is raised again. This repeats until the pending flag clears.
- R5: While another agent holds `clkRunIn` low, `clkRunOe` is never raised. A change seen in that time stays pending until the completion pulse.
- R6: While `serIrqEn` is 0, no new drive starts, but changes are still recorded in `changePending`.
- R7: `cycleDone` clears `changePending` at the next edge, unless a change is detected in the same cycle, in which case the flag stays 1.
- R8: Reset (active-low `rstN`, asynchronous) clears `changePending`, `clkRunOe` and the synchronizer and history stages, all to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serIrqEn | input | 1 | Serial interrupt function enabled |
| irqLines | input | NUM_IRQ | Interrupt request lines, asynchronous |
| clkRunIn | input | 1 | Sampled level of the shared clock-run line (0 = clock requested) |
| cycleDone | input | 1 | One-cycle pulse: a serial interrupt cycle has finished |
| clkRunOe | output | 1 | Open-drain enable; 1 pulls the clock-run line low |
| changePending | output | 1 | An interrupt change is waiting for delivery |

## Verification
The assertions assume that `clkRunIn` is already a clean signal in the clock domain, and that it reads low whenever this block drives it. The stimulus meets this by building the line as a wired-AND of the block's own enable and a host pull-down. The bench changes every input on the falling edge. `cycleDone` is only ever a single-cycle pulse. Interrupt toggles are swept against that pulse at several offsets so that the coincident case of R7 is reached.

// File: rtl/clkrun_pkg.sv
package clkrun_pkg;
  typedef struct packed {
    logic cntClear;
    logic cntStep;
  } ctlStrobe_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRIVE = 1'b1
  } runState_t;
endpackage

// File: rtl/clkrun_datapath.sv
module clkrun_datapath
  import clkrun_pkg::*;
#(
  parameter int NUM_IRQ   = 16,
  parameter int MIN_DRIVE = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqLines,
  input  ctlStrobe_t         strobe,
  output logic               anyChange,
  output logic               cntDone
);
  localparam int CW = $clog2(MIN_DRIVE + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(MIN_DRIVE);

  logic [NUM_IRQ-1:0] irqMeta, irqSync, irqPrev;
  logic [CW-1:0]      driveCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqMeta <= '0;
      irqSync <= '0;
      irqPrev <= '0;
    end else begin
      irqMeta <= irqLines;
      irqSync <= irqMeta;
      irqPrev <= irqSync;
    end
  end

  assign anyChange = |(irqSync ^ irqPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveCnt <= '0;
    end else if (strobe.cntClear) begin
      driveCnt <= CW'(1);
    end else if (strobe.cntStep) begin
      driveCnt <= driveCnt + 1'b1;
    end
  end

  assign cntDone = (driveCnt >= CNT_LAST);

  assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    driveCnt <= CNT_LAST);

  assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.cntClear && strobe.cntStep));
endmodule

// File: rtl/clkrun_control.sv
module clkrun_control
  import clkrun_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       serIrqEn,
  input  logic       clkRunIn,
  input  logic       cycleDone,
  input  logic       anyChange,
  input  logic       cntDone,
  output ctlStrobe_t strobe,
  output logic       runOe,
  output logic       pendQ
);
  runState_t state, nextState;
  logic      pendNext;
  logic      startReq;

  assign startReq = pendQ && serIrqEn && clkRunIn;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          nextState       = ST_DRIVE;
          strobe.cntClear = 1'b1;
        end
      end
      ST_DRIVE: begin
        if (cntDone) nextState = ST_IDLE;
        else         strobe.cntStep = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    if (anyChange)      pendNext = 1'b1;
    else if (cycleDone) pendNext = 1'b0;
    else                pendNext = pendQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pendQ <= 1'b0;
    end else begin
      state <= nextState;
      pendQ <= pendNext;
    end
  end

  assign runOe = (state == ST_DRIVE);

  assert_change_sets_pending_R1: assert property (@(posedge clk) disable iff (!rstN)
    anyChange |=> pendQ);

  assert_rise_needs_request_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runOe) |-> $past(pendQ && serIrqEn && clkRunIn));

  assert_drive_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (runOe && !cntDone) |=> runOe);

  assert_drive_releases_R3: assert property (@(posedge clk) disable iff (!rstN)
    (runOe && cntDone) |=> !runOe);

  assert_no_fight_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!runOe && !clkRunIn) |=> !runOe);

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!runOe && !serIrqEn) |=> !runOe);

  assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDone && !anyChange) |=> !pendQ);
endmodule

// File: rtl/clkRunReq.sv
module clkRunReq
  import clkrun_pkg::*;
#(
  parameter int NUM_IRQ   = 16,
  parameter int MIN_DRIVE = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serIrqEn,
  input  logic [NUM_IRQ-1:0] irqLines,
  input  logic               clkRunIn,
  input  logic               cycleDone,
  output logic               clkRunOe,
  output logic               changePending
);
  ctlStrobe_t strobe;
  logic       anyChange;
  logic       cntDone;

  clkrun_datapath #(.NUM_IRQ(NUM_IRQ), .MIN_DRIVE(MIN_DRIVE)) uDatapath (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .strobe(strobe),
    .anyChange(anyChange), .cntDone(cntDone)
  );

  clkrun_control uControl (
    .clk(clk), .rstN(rstN), .serIrqEn(serIrqEn), .clkRunIn(clkRunIn),
    .cycleDone(cycleDone), .anyChange(anyChange), .cntDone(cntDone),
    .strobe(strobe), .runOe(clkRunOe), .pendQ(changePending)
  );
endmodule

// File: tb/tb_clkRunReq.sv
module tb_clkRunReq;
  localparam int NUM_IRQ   = 16;
  localparam int MIN_DRIVE = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIrqEn = 1'b0;
  logic [NUM_IRQ-1:0] irqLines = '0;
  logic cycleDone = 1'b0;
  logic hostLow = 1'b0;
  logic clkRunIn;
  logic clkRunOe, changePending;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string curReq = "R8";
  int oeRises = 0;
  logic lastOe = 1'b0;

  assign clkRunIn = ~(clkRunOe | hostLow);

  always #5 clk = ~clk;

  clkRunReq #(.NUM_IRQ(NUM_IRQ), .MIN_DRIVE(MIN_DRIVE)) dut (
    .clk(clk), .rstN(rstN), .serIrqEn(serIrqEn), .irqLines(irqLines),
    .clkRunIn(clkRunIn), .cycleDone(cycleDone),
    .clkRunOe(clkRunOe), .changePending(changePending)
  );

  // Behavioural reference, updated once per rising edge
  logic [NUM_IRQ-1:0] mQ[3];
  logic mPend, mOe;
  int   mCnt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) mQ[i] = '0;
      mPend = 0; mOe = 0; mCnt = 0;
    end else begin
      logic chg, nPend;
      chg   = (mQ[1] != mQ[2]);
      nPend = chg ? 1'b1 : (cycleDone ? 1'b0 : mPend);
      if (!mOe) begin
        if (mPend && serIrqEn && clkRunIn) begin mOe = 1; mCnt = 1; end
      end else if (mCnt >= MIN_DRIVE) mOe = 0;
      else mCnt++;
      mQ[2] = mQ[1]; mQ[1] = mQ[0]; mQ[0] = irqLines;
      mPend = nPend;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check(curReq, clkRunOe, mOe, "clkRunOe");
      check(curReq, changePending, mPend, "changePending");
      if (clkRunOe && !lastOe) oeRises++;
      lastOe = clkRunOe;
    end
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseDone();
    cycleDone = 1'b1; cyc(1); cycleDone = 1'b0;
  endtask

  initial begin
    cyc(3);
    check("R8", clkRunOe, 1'b0, "oe in reset");
    check("R8", changePending, 1'b0, "pending in reset");
    rstN = 1'b1;
    cyc(2);
    check("R8", changePending, 1'b0, "pending after reset");

    // R1..R4: change with host idle, line floats high
    curReq = "R1/R2/R3/R4"; serIrqEn = 1'b1; oeRises = 0;
    irqLines[3] = 1'b1;
    cyc(2);
    check("R1", changePending, 1'b0, "not yet pending after two edges");
    cyc(1);
    check("R1", changePending, 1'b1, "pending at third edge");
    cyc(14);
    check("R4", logic'(oeRises >= 3), 1'b1, "repeated drives");
    curReq = "R7"; pulseDone(); cyc(6);
    check("R7", changePending, 1'b0, "cleared by cycleDone");

    // R5: host already holds the line low
    curReq = "R5"; hostLow = 1'b1; oeRises = 0;
    irqLines[3] = 1'b0; irqLines[9] = 1'b1;
    cyc(12);
    check("R5", logic'(oeRises), 1'b0, "no drive while host low");
    check("R5", changePending, 1'b1, "pending held");
    pulseDone(); cyc(3); hostLow = 1'b0; cyc(4);

    // R6: disabled, change still recorded, drive once enabled
    curReq = "R6"; serIrqEn = 1'b0; oeRises = 0;
    irqLines = 16'hA5A5;
    cyc(10);
    check("R6", logic'(oeRises), 1'b0, "no drive while disabled");
    check("R6", changePending, 1'b1, "pending recorded while disabled");
    serIrqEn = 1'b1; cyc(4);
    check("R6", logic'(oeRises >= 1), 1'b1, "drive after enable");
    pulseDone(); cyc(5);

    // R7: completion pulse at several offsets from a change
    curReq = "R7";
    for (int off = 0; off < 6; off++) begin
      irqLines[0] = ~irqLines[0];
      cyc(off);
      pulseDone();
      cyc(6);
      pulseDone();
      cyc(4);
    end

    // R8: reset mid-drive
    curReq = "R8"; irqLines[15] = ~irqLines[15];
    cyc(4);
    rstN = 1'b0; cyc(1);
    check("R8", clkRunOe, 1'b0, "oe during mid reset");
    check("R8", changePending, 1'b0, "pending during mid reset");
    rstN = 1'b1; cyc(6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule